// File: doc/BRIEF.md
# Multi-Issue Register Scoreboard

This block keeps a per-register record of pending results for a core that presents up to four instructions per clock, as one issue group, to execution pipelines of unequal latency. It then decides, slot by slot, whether each instruction in the group may leave its decode stage in this cycle. An instruction is held when a source it needs has not been produced yet. It is also held when it would write a register that still has an outstanding write, or one written by an older member of the same group. Held instructions keep their slot. The issuer presents them again, and once a slot clears, the next instruction takes its place.

Each of the 32 registers has a small state machine with two states. In REG_READY the register contents are current. In REG_PENDING a result is outstanding, and the entry stores the tag of the instruction that owns that result. The transitions are as follows:
- READY to PENDING (mark): a slot that writes the register goes.
- PENDING to READY (retire): a writeback arrives with a matching register index and owner tag.
- PENDING to PENDING (retag): a new writer goes in the same cycle as the retire.
- PENDING holds: any other writeback leaves the entry unchanged.

Register 0 reads as zero and is never marked. A writeback that retires a register in the same cycle a reader is waiting for it is forwarded: the reader goes, and a select bit names the writeback port that supplies the operand.

Top module: `multi_issue_scoreboard`

## Requirements
- R1: After reset every register is in REG_READY, so a group whose slots use distinct registers and have no intra-group dependences goes in full (slot_go = 4'b1111); a group with no valid slot gives slot_go = 0.
- R2: A slot that goes with slot_wr set and a nonzero destination marks that register pending under slot_tag from the next cycle, so a later reader of it is held.
- R3: A slot whose source register is pending is held until a writeback carries that register's index and its owner tag. In that cycle the slot goes, and the forward select bit at index slot*2+port of fwd_a (source A) or fwd_b (source B) is 1. Once the register is retired, later reads go with the select bits at 0.
- R4: A writeback whose tag differs from the stored owner tag leaves the register pending, and its readers stay held.
- R5: A slot that reads a register written by an older slot going in the same cycle is held.
- R6: Hazards are resolved in program order, where slot 0 is the oldest. A valid slot that is held also holds every younger slot, while a slot with slot_valid low neither goes nor holds younger slots.
- R7: A slot that writes a register is held while that register is still pending after this cycle's writebacks, or while an older slot that goes in the same cycle writes the same register.
- R8: A younger slot that writes a register read by an older slot that goes in the same cycle is not held on that account, because the older slot captures the old value in that cycle.
- R9: Register 0 is never marked pending. Writes to it do not mark it, and reads of it never hold a slot.
- R10: When a register is retired and re-marked by a new writer in the same cycle, the writer goes and the register stays pending under the new writer's tag. A writeback carrying the old tag no longer retires it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 4 | Slot holds an instruction |
| slot_src_a | input | 20 | Source A register index, 5 bits per slot |
| slot_src_b | input | 20 | Source B register index, 5 bits per slot |
| slot_dst | input | 20 | Destination register index, 5 bits per slot |
| slot_wr | input | 4 | Slot writes its destination |
| slot_tag | input | 16 | Result tag per slot, 4 bits per slot |
| wb_valid | input | 2 | Writeback port carries a result |
| wb_reg | input | 10 | Writeback register index, 5 bits per port |
| wb_tag | input | 8 | Writeback result tag, 4 bits per port |
| slot_go | output | 4 | Slot may leave its first stage this cycle |
| fwd_a | output | 8 | Source A taken from writeback port, bit slot*2+port |
| fwd_b | output | 8 | Source B taken from writeback port, bit slot*2+port |

## Verification
The assertions check four things on every cycle. No slot goes while a source it reads is still pending after the writebacks. No slot goes past an older held slot. A mark always follows a going writer. Register 0 stays ready, and a pending register only leaves that state through a matching writeback. The bench scenarios are needed for the rest: the cycle in which a held reader is released, which writeback port the forward select names, tag mismatches that must not retire, the same-cycle retire-and-retag case, and the group-internal cases of RAW, WAW and the permitted WAR.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic {
        REG_READY   = 1'b0,
        REG_PENDING = 1'b1
    } sb_state_e;
endpackage

// File: rtl/sb_entry.sv
module sb_entry
    import sb_pkg::*;
#(
    parameter int IDX  = 1,
    parameter int NREG = 32,
    parameter int NWB  = 2,
    parameter int TW   = 4,
    localparam int RW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [TW-1:0]   set_tag,
    input  logic [NWB-1:0]  wb_valid,
    input  logic [NWB*RW-1:0] wb_reg,
    input  logic [NWB*TW-1:0] wb_tag,
    output logic            pend_eff,
    output logic [NWB-1:0]  clr_port
);
    localparam logic [RW-1:0] MY_IDX = RW'(IDX);

    sb_state_e     state, state_nx;
    logic [TW-1:0] owner, owner_nx;

    // retire match per writeback port
    always_comb begin
        for (int p = 0; p < NWB; p++) begin
            clr_port[p] = (state == REG_PENDING) && wb_valid[p]
                       && (wb_reg[p*RW +: RW] == MY_IDX)
                       && (wb_tag[p*TW +: TW] == owner);
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        owner_nx = owner;
        unique case (state)
            REG_READY: begin
                if (set_en) begin
                    state_nx = REG_PENDING;
                    owner_nx = set_tag;
                end
            end
            REG_PENDING: begin
                if (set_en) begin
                    owner_nx = set_tag;
                end else if (|clr_port) begin
                    state_nx = REG_READY;
                end
            end
            default: state_nx = REG_READY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= REG_READY;
            owner <= '0;
        end else begin
            state <= state_nx;
            owner <= owner_nx;
        end
    end

    // outputs
    always_comb begin
        pend_eff = (state == REG_PENDING) && !(|clr_port);
    end

    assert_mark_after_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> (state == REG_PENDING));

    assert_zero_never_marked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (IDX != 0) || (state == REG_READY));

    assert_tag_guard_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == REG_PENDING && !set_en && !(|clr_port))
            |=> (state == REG_PENDING && $stable(owner)));
endmodule

// File: rtl/sb_issue_check.sv
module sb_issue_check #(
    parameter int NREG  = 32,
    parameter int NSLOT = 4,
    localparam int RW   = $clog2(NREG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSLOT-1:0]    slot_valid,
    input  logic [NSLOT*RW-1:0] slot_src_a,
    input  logic [NSLOT*RW-1:0] slot_src_b,
    input  logic [NSLOT*RW-1:0] slot_dst,
    input  logic [NSLOT-1:0]    slot_wr,
    input  logic [NREG-1:0]     pend_eff,
    output logic [NSLOT-1:0]    slot_go
);
    // in-order hazard walk across the group
    always_comb begin : walk
        logic            blocked;
        logic            haz;
        logic [NREG-1:0] wmask;
        logic [RW-1:0]   a, b, d;
        blocked = 1'b0;
        wmask   = '0;
        for (int i = 0; i < NSLOT; i++) begin
            a   = slot_src_a[i*RW +: RW];
            b   = slot_src_b[i*RW +: RW];
            d   = slot_dst[i*RW +: RW];
            haz = 1'b0;
            if (a != '0 && (pend_eff[a] || wmask[a])) haz = 1'b1;
            if (b != '0 && (pend_eff[b] || wmask[b])) haz = 1'b1;
            if (slot_wr[i] && d != '0 && (pend_eff[d] || wmask[d])) haz = 1'b1;
            slot_go[i] = slot_valid[i] && !haz && !blocked;
            if (slot_valid[i] && !slot_go[i]) blocked = 1'b1;
            if (slot_go[i] && slot_wr[i] && d != '0) wmask[d] = 1'b1;
        end
    end

    for (genvar gi = 0; gi < NSLOT; gi++) begin : g_chk
        assert_raw_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
            slot_go[gi] |-> !pend_eff[slot_src_a[gi*RW +: RW]]
                         && !pend_eff[slot_src_b[gi*RW +: RW]]);
        if (gi > 0) begin : g_ord
            assert_in_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
                slot_go[gi] |-> ((slot_valid[gi-1:0] & ~slot_go[gi-1:0]) == '0));
        end
    end
endmodule

// File: rtl/multi_issue_scoreboard.sv
module multi_issue_scoreboard #(
    parameter int NREG  = 32,
    parameter int NSLOT = 4,
    parameter int NWB   = 2,
    parameter int TW    = 4,
    localparam int RW   = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSLOT-1:0]        slot_valid,
    input  logic [NSLOT*RW-1:0]     slot_src_a,
    input  logic [NSLOT*RW-1:0]     slot_src_b,
    input  logic [NSLOT*RW-1:0]     slot_dst,
    input  logic [NSLOT-1:0]        slot_wr,
    input  logic [NSLOT*TW-1:0]     slot_tag,
    input  logic [NWB-1:0]          wb_valid,
    input  logic [NWB*RW-1:0]       wb_reg,
    input  logic [NWB*TW-1:0]       wb_tag,
    output logic [NSLOT-1:0]        slot_go,
    output logic [NSLOT*NWB-1:0]    fwd_a,
    output logic [NSLOT*NWB-1:0]    fwd_b
);
    logic [NREG-1:0] pend_eff;
    logic [NREG-1:0] set_en;
    logic [TW-1:0]   set_tag [NREG];
    logic [NWB-1:0]  clr_port [NREG];

    // marks from going writers (register 0 excluded)
    always_comb begin
        set_en = '0;
        for (int r = 0; r < NREG; r++) set_tag[r] = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (slot_go[i] && slot_wr[i] && slot_dst[i*RW +: RW] != '0) begin
                set_en[slot_dst[i*RW +: RW]]  = 1'b1;
                set_tag[slot_dst[i*RW +: RW]] = slot_tag[i*TW +: TW];
            end
        end
    end

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        sb_entry #(.IDX(r), .NREG(NREG), .NWB(NWB), .TW(TW)) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_en   (set_en[r]),
            .set_tag  (set_tag[r]),
            .wb_valid (wb_valid),
            .wb_reg   (wb_reg),
            .wb_tag   (wb_tag),
            .pend_eff (pend_eff[r]),
            .clr_port (clr_port[r])
        );
    end

    sb_issue_check #(.NREG(NREG), .NSLOT(NSLOT)) u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_valid (slot_valid),
        .slot_src_a (slot_src_a),
        .slot_src_b (slot_src_b),
        .slot_dst   (slot_dst),
        .slot_wr    (slot_wr),
        .pend_eff   (pend_eff),
        .slot_go    (slot_go)
    );

    // forward selects: operand supplied by the retiring writeback
    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            for (int p = 0; p < NWB; p++) begin
                fwd_a[i*NWB+p] = slot_go[i] && clr_port[slot_src_a[i*RW +: RW]][p];
                fwd_b[i*NWB+p] = slot_go[i] && clr_port[slot_src_b[i*RW +: RW]][p];
            end
        end
    end
endmodule

// File: tb/multi_issue_scoreboard_bench.sv
module multi_issue_scoreboard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  slot_valid;
    logic [19:0] slot_src_a, slot_src_b, slot_dst;
    logic [3:0]  slot_wr;
    logic [15:0] slot_tag;
    logic [1:0]  wb_valid;
    logic [9:0]  wb_reg;
    logic [7:0]  wb_tag;
    logic [3:0]  slot_go;
    logic [7:0]  fwd_a, fwd_b;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    multi_issue_scoreboard u_multi_issue_scoreboard (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_src_a(slot_src_a),
        .slot_src_b(slot_src_b), .slot_dst(slot_dst), .slot_wr(slot_wr),
        .slot_tag(slot_tag), .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_tag(wb_tag),
        .slot_go(slot_go), .fwd_a(fwd_a), .fwd_b(fwd_b)
    );

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<=5000", cycles);
            summary();
        end
    end

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic clear_in();
        slot_valid = '0; slot_src_a = '0; slot_src_b = '0; slot_dst = '0;
        slot_wr = '0; slot_tag = '0; wb_valid = '0; wb_reg = '0; wb_tag = '0;
    endtask

    task automatic put(int i, logic [4:0] a, logic [4:0] b, logic wr, logic [4:0] d, logic [3:0] t);
        slot_valid[i] = 1'b1;
        slot_src_a[i*5 +: 5] = a;
        slot_src_b[i*5 +: 5] = b;
        slot_wr[i] = wr;
        slot_dst[i*5 +: 5] = d;
        slot_tag[i*4 +: 4] = t;
    endtask

    task automatic wb(int p, logic [4:0] r, logic [3:0] t);
        wb_valid[p] = 1'b1;
        wb_reg[p*5 +: 5] = r;
        wb_tag[p*4 +: 4] = t;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        clear_in();
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic t_reset_and_mark();
        settle();
        check("R1 empty group", {4'b0, slot_go}, 8'h00);
        put(0, 0, 0, 1, 1, 1); put(1, 0, 0, 1, 2, 2);
        put(2, 0, 0, 1, 3, 3); put(3, 0, 0, 1, 4, 4);
        settle();
        check("R1 independent group", {4'b0, slot_go}, 8'h0F);
        tick();
        put(0, 1, 0, 0, 0, 0); put(1, 0, 0, 0, 0, 0);
        settle();
        check("R2 reader of marked r1", {4'b0, slot_go}, 8'h00);
        tick();
        put(0, 0, 0, 1, 0, 7);
        settle();
        check("R9 write to r0", {4'b0, slot_go}, 8'h01);
        tick();
        put(0, 0, 0, 0, 0, 0);
        settle();
        check("R9 read of r0", {4'b0, slot_go}, 8'h01);
        tick();
    endtask

    task automatic t_retire();
        put(0, 0, 1, 0, 0, 0); wb(1, 1, 5);
        settle();
        check("R4 tag mismatch", {4'b0, slot_go}, 8'h00);
        tick();
        put(0, 0, 1, 0, 0, 0); wb(1, 1, 1);
        settle();
        check("R3 release on match", {4'b0, slot_go}, 8'h01);
        check("R3 fwd_b port1 slot0", fwd_b, 8'b0000_0010);
        check("R3 fwd_a idle", fwd_a, 8'h00);
        tick();
        put(0, 0, 1, 0, 0, 0);
        settle();
        check("R3 after retire go", {4'b0, slot_go}, 8'h01);
        check("R3 after retire no fwd", fwd_b, 8'h00);
        wb(0, 2, 2); wb(1, 3, 3);
        tick();
        wb(0, 4, 4);
        tick();
        put(0, 2, 0, 0, 0, 0); put(1, 3, 0, 0, 0, 0); put(2, 4, 0, 0, 0, 0);
        settle();
        check("R3 all retired", {4'b0, slot_go}, 8'h07);
        tick();
    endtask

    task automatic t_group_order();
        put(0, 0, 0, 1, 6, 6); put(1, 6, 0, 0, 0, 0); put(2, 7, 0, 0, 0, 0);
        settle();
        check("R5 intra-group RAW", {4'b0, slot_go}, 8'h01);
        tick();
        put(1, 8, 0, 0, 0, 0); put(2, 0, 0, 0, 0, 0); put(3, 6, 0, 0, 0, 0);
        settle();
        check("R6 empty slot no block", {4'b0, slot_go}, 8'h06);
        tick();
    endtask

    task automatic t_waw_retag();
        put(0, 0, 0, 1, 6, 9);
        settle();
        check("R7 writer of pending r6", {4'b0, slot_go}, 8'h00);
        wb(0, 6, 6);
        settle();
        check("R10 retire and retag", {4'b0, slot_go}, 8'h01);
        tick();
        put(0, 6, 0, 0, 0, 0); wb(0, 6, 6);
        settle();
        check("R10 old tag no longer retires", {4'b0, slot_go}, 8'h00);
        tick();
        put(0, 6, 0, 0, 0, 0); wb(0, 6, 9);
        settle();
        check("R10 new tag retires", {4'b0, slot_go}, 8'h01);
        check("R3 fwd_a port0 slot0", fwd_a, 8'b0000_0001);
        tick();
        put(0, 0, 0, 1, 10, 10); put(1, 0, 0, 1, 10, 11);
        settle();
        check("R7 intra-group WAW", {4'b0, slot_go}, 8'h01);
        tick();
        wb(0, 10, 10);
        tick();
    endtask

    task automatic t_war();
        put(0, 11, 0, 1, 12, 12); put(1, 0, 0, 1, 11, 13); put(2, 11, 0, 0, 0, 0);
        settle();
        check("R8 younger writer of older source", {4'b0, slot_go}, 8'h03);
        tick();
    endtask

    initial begin
        clear_in();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset_and_mark();
        t_retire();
        t_group_order();
        t_waw_retag();
        t_war();
        summary();
    end
endmodule